// File: doc/BRIEF.md
# SRv6 Destination Rewrite Stage

This block is one stage of a packet-processing pipeline that works on already-parsed header vectors. For each packet, a per-packet strobe marks the cycle that carries its header fields. If the segment-routing extension is present, the stage acts on the packet. It puts the final entry of the segment list into the IPv6 destination address. In the same step, it lowers the segments-remaining counter by one.

The stage has no lookup key. It always applies its one action when the stage is enabled and the packet's segment header is flagged valid. Every other packet goes through with its fields unchanged. The result is registered, so it reaches the next stage exactly one cycle later and in the same order. The next stage is the egress-port table, which therefore matches on the rewritten destination.

A counter that is already zero is not wrapped. It stays at zero, and the packet leaves with an error flag set.

Top module: `srv6_dst_rewrite`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_vld` and `out_err` are 0 and `out_dst`, `out_seg_left` and `out_rest` are all zero.
- R2: `out_vld` in a cycle equals `in_vld` of the previous cycle; every accepted header appears exactly one cycle after it was presented, in arrival order.
- R3: When `in_vld`, `stage_en` and `in_seg_vld` are all 1, `out_dst` one cycle later equals `in_last_seg`.
- R4: In that same case, with `in_seg_left` non-zero, `out_seg_left` one cycle later equals `in_seg_left` minus one and `out_err` is 0.
- R5: In that same case, with `in_seg_left` equal to zero, `out_seg_left` one cycle later is zero (no wrap to all ones) and `out_err` is 1.
- R6: When `in_vld` is 1 and `in_seg_vld` is 0, `out_dst` and `out_seg_left` one cycle later equal `in_dst` and `in_seg_left`, and `out_err` is 0.
- R7: When `in_vld` is 1 and `stage_en` is 0, the packet passes through as in R6, whatever `in_seg_vld` is.
- R8: `out_rest` and `out_seg_vld` one cycle after an accepted header equal `in_rest` and `in_seg_vld`, whether or not the packet was rewritten.
- R9: A cycle with `in_vld` at 0 leaves `out_dst`, `out_seg_left`, `out_rest`, `out_seg_vld` and `out_err` at their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stage_en | input | 1 | Enables the rewrite action |
| in_vld | input | 1 | Header vector present this cycle |
| in_seg_vld | input | 1 | Segment-routing header parsed as valid |
| in_dst | input | ADDR_W (128) | IPv6 destination address |
| in_last_seg | input | ADDR_W (128) | Value of the last segment in the list |
| in_seg_left | input | SL_W (8) | Segments-remaining counter |
| in_rest | input | REST_W (64) | Other header fields, carried unchanged |
| out_vld | output | 1 | Header vector present for the egress table |
| out_seg_vld | output | 1 | Copy of the segment-valid flag |
| out_dst | output | ADDR_W (128) | Destination address, possibly rewritten |
| out_seg_left | output | SL_W (8) | Segments-remaining counter, possibly decremented |
| out_rest | output | REST_W (64) | Other header fields |
| out_err | output | 1 | Decrement attempted on a zero counter |

## Verification
Every result of this stage comes out one cycle after its header is presented. The bench drives inputs on the falling edge and keeps a behavioural model that it updates from those inputs on the next rising edge. It compares all outputs at the falling edge after that, so each comparison happens after exactly one register stage. Idle cycles go through the same comparison, which covers the hold behaviour. Each checked field carries the tag of the requirement that applies to the packet's category: rewritten, zero-counter, segment-invalid or disabled.

// File: rtl/srv6_dst_rewrite.sv
module srv6_dst_rewrite #(
  parameter int ADDR_W = 128,
  parameter int SL_W   = 8,
  parameter int REST_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stage_en,
  input  logic              in_vld,
  input  logic              in_seg_vld,
  input  logic [ADDR_W-1:0] in_dst,
  input  logic [ADDR_W-1:0] in_last_seg,
  input  logic [SL_W-1:0]   in_seg_left,
  input  logic [REST_W-1:0] in_rest,
  output logic              out_vld,
  output logic              out_seg_vld,
  output logic [ADDR_W-1:0] out_dst,
  output logic [SL_W-1:0]   out_seg_left,
  output logic [REST_W-1:0] out_rest,
  output logic              out_err
);

  localparam logic [SL_W-1:0] SL_ONE = SL_W'(1);

  logic act, sl_zero;
  logic [SL_W-1:0] sl_next;

  assign act     = stage_en & in_seg_vld;
  assign sl_zero = (in_seg_left == '0);
  assign sl_next = (act && !sl_zero) ? in_seg_left - SL_ONE : in_seg_left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld      <= 1'b0;
      out_seg_vld  <= 1'b0;
      out_dst      <= '0;
      out_seg_left <= '0;
      out_rest     <= '0;
      out_err      <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_seg_vld  <= in_seg_vld;
        out_dst      <= act ? in_last_seg : in_dst;
        out_seg_left <= sl_next;
        out_rest     <= in_rest;
        out_err      <= act & sl_zero;
      end
    end
  end

  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_vld == $past(in_vld));

  a_r3_copy_seg: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && stage_en && in_seg_vld) |=> out_dst == $past(in_last_seg));

  a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && stage_en && in_seg_vld && in_seg_left != '0)
      |=> (out_seg_left == $past(in_seg_left) - SL_ONE) && !out_err);

  a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && stage_en && in_seg_vld && in_seg_left == '0)
      |=> out_seg_left == '0 && out_err);

  a_r6_r7_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !(stage_en && in_seg_vld))
      |=> out_dst == $past(in_dst) && out_seg_left == $past(in_seg_left) && !out_err);

  a_r8_carry: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_rest == $past(in_rest) && out_seg_vld == $past(in_seg_vld));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(out_dst) && $stable(out_seg_left) && $stable(out_rest)
                && $stable(out_err) && $stable(out_seg_vld));

endmodule

// File: tb/test_srv6_dst_rewrite.sv
module test_srv6_dst_rewrite;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 128;
  localparam int SL_W   = 8;
  localparam int REST_W = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stage_en = 1'b0, in_vld = 1'b0, in_seg_vld = 1'b0;
  logic [ADDR_W-1:0] in_dst = '0, in_last_seg = '0;
  logic [SL_W-1:0]   in_seg_left = '0;
  logic [REST_W-1:0] in_rest = '0;
  logic out_vld, out_seg_vld, out_err;
  logic [ADDR_W-1:0] out_dst;
  logic [SL_W-1:0]   out_seg_left;
  logic [REST_W-1:0] out_rest;

  int checks = 0;
  int errors = 0;

  logic e_vld = 1'b0, e_sv = 1'b0, e_err = 1'b0;
  logic [ADDR_W-1:0] e_dst = '0;
  logic [SL_W-1:0]   e_sl = '0;
  logic [REST_W-1:0] e_rest = '0;
  string dst_tag = "R1", sl_tag = "R1";

  always #(CLK_P/2) clk = ~clk;

  srv6_dst_rewrite #(.ADDR_W(ADDR_W), .SL_W(SL_W), .REST_W(REST_W)) i_srv6_dst_rewrite (
    .clk(clk), .rst_n(rst_n), .stage_en(stage_en), .in_vld(in_vld),
    .in_seg_vld(in_seg_vld), .in_dst(in_dst), .in_last_seg(in_last_seg),
    .in_seg_left(in_seg_left), .in_rest(in_rest), .out_vld(out_vld),
    .out_seg_vld(out_seg_vld), .out_dst(out_dst), .out_seg_left(out_seg_left),
    .out_rest(out_rest), .out_err(out_err));

  task automatic check(input string req, input logic [ADDR_W-1:0] act, input logic [ADDR_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R2 out_vld", ADDR_W'(out_vld), ADDR_W'(e_vld));
    check({dst_tag, " out_dst"}, out_dst, e_dst);
    check({sl_tag, " out_seg_left"}, ADDR_W'(out_seg_left), ADDR_W'(e_sl));
    check({sl_tag, " out_err"}, ADDR_W'(out_err), ADDR_W'(e_err));
    check("R8 out_rest", ADDR_W'(out_rest), ADDR_W'(e_rest));
    check("R8 out_seg_vld", ADDR_W'(out_seg_vld), ADDR_W'(e_sv));
  endtask

  // drive at the falling edge, model at the rising edge, compare at the next falling edge
  task automatic step(input logic v, input logic en, input logic sv,
                      input logic [ADDR_W-1:0] d, input logic [ADDR_W-1:0] ls,
                      input logic [SL_W-1:0] sl, input logic [REST_W-1:0] r);
    in_vld = v; stage_en = en; in_seg_vld = sv;
    in_dst = d; in_last_seg = ls; in_seg_left = sl; in_rest = r;
    @(posedge clk);
    e_vld = v;
    if (v) begin
      e_rest = r;
      e_sv = sv;
      if (en && sv) begin
        e_dst = ls;
        dst_tag = "R3";
        if (sl == 0) begin e_sl = 0; e_err = 1'b1; sl_tag = "R5"; end
        else begin e_sl = sl - 1; e_err = 1'b0; sl_tag = "R4"; end
      end else begin
        e_dst = d;
        e_sl = sl;
        e_err = 1'b0;
        dst_tag = en ? "R6" : "R7";
        sl_tag = dst_tag;
      end
    end else begin
      dst_tag = "R9";
      sl_tag = "R9";
    end
    @(negedge clk);
    compare_all();
  endtask

  function automatic logic [ADDR_W-1:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  initial begin
    #(CLK_P * 100000);
    errors++;
    checks++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare_all();
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();

    step(1, 1, 1, 128'h2001_0db8_0000_0000_0000_0000_0000_0001, 128'hfc00_0000_0000_0000_0000_0000_0000_00aa, 8'd3, 64'h1111);
    step(1, 1, 1, 128'h1, 128'h2, 8'd1, 64'h2222);
    step(1, 1, 1, 128'h3, 128'h4, 8'd0, 64'h3333);
    step(1, 1, 1, 128'h5, 128'h6, 8'hff, 64'h4444);
    step(1, 1, 0, 128'h7, 128'h8, 8'd5, 64'h5555);
    step(1, 1, 0, 128'h9, 128'ha, 8'd0, 64'h6666);
    step(1, 0, 1, 128'hb, 128'hc, 8'd2, 64'h7777);
    step(1, 0, 1, 128'hd, 128'he, 8'd0, 64'h8888);
    step(1, 1, 1, 128'hf, 128'h10, 8'd0, 64'h9999);
    step(0, 1, 1, 128'h11, 128'h12, 8'd9, 64'haaaa);
    step(0, 0, 0, 128'h13, 128'h14, 8'd0, 64'hbbbb);
    step(1, 1, 1, 128'h15, 128'h16, 8'd7, 64'hcccc);

    for (int i = 0; i < 400; i++) begin
      logic [SL_W-1:0] sl;
      sl = ($urandom() % 4 == 0) ? '0 : SL_W'($urandom());
      step(1'($urandom() % 4 != 0), 1'($urandom() % 5 != 0), 1'($urandom() % 3 != 0),
           rnd128(), rnd128(), sl, {$urandom(), $urandom()});
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule